// File: doc/BRIEF.md
# Rate-Limited Relay Output Register

This block is a host-written latch for a bank of discrete control outputs. These outputs drive relays, triacs and open-collector style loads. The host writes a data word to the output address. Each bit then appears on its pin and stays there until the host writes again. The pins are active-low. A bit written as 0 pulls its pin low and energizes the load. A bit written as 1 releases the pin high, so the external pull-up sets its level and the load is off.

Two of the bits are guarded by anti-recycle timers: the compressor start (bit `CMP_BIT`, default bit 0) and the pump start (bit `PMP_BIT`, default bit 1). A guarded pin may change only after a minimum interval has passed since its previous change. The interval is `CMP_SEC` seconds (default 20) for the compressor and `PMP_SEC` seconds (default 10) for the pump. A second is `CYC_PER_SEC` clock cycles. The timer is restarted only by a real change of the pin. A request that arrives too early is held as pending and is applied in the cycle the interval runs out. A later write replaces or cancels it. A read port returns the driven pin state and the pending flags.

Top module: `relay_out`

## Requirements
- R1: After reset every pin is high (0xFF for 8 outputs) and both pending flags read 0. Both guards start expired, so the first write to a guarded bit takes effect in the cycle after the write.
- R2: A write to address 0 copies each unguarded data bit to its pin on the next clock edge, and the pin holds that value until it is written again. A 0 drives the pin low (load on) and a 1 releases it high (load off).
- R3: A write to any address other than 0 leaves every pin and pending flag unchanged.
- R4: The compressor pin (bit `CMP_BIT`) changes at most once per `CMP_SEC*CYC_PER_SEC` cycles. A request made at or after that point takes effect on the next edge.
- R5: The pump pin (bit `PMP_BIT`) changes at most once per `PMP_SEC*CYC_PER_SEC` cycles. A request made at or after that point takes effect on the next edge.
- R6: A write that would change a guarded pin before its interval ends sets that guard's pending flag and leaves the pin unchanged. The held value is driven on exactly the edge where the interval ends, and the flag then clears. The flags are read at address 1: bit 0 is the compressor flag and bit 1 is the pump flag.
- R7: A write to address 0 whose guarded bit equals the current pin cancels that guard's pending request. The pin then stays unchanged when the interval ends.
- R8: A write that does not change a guarded pin does not restart that guard's timer.
- R9: Suppose a write arrives on the same edge where a pending request would be applied. The write wins. If its bit equals the current pin, the pin stays as it is and the pending flag clears.
- R10: A read at address 0 returns the driven pin state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address (0 = output word) |
| wrData | input | NUM_OUT | Write data, 0 = energize |
| rdAddr | input | ADDR_W | Read address (0 = pins, 1 = pending flags) |
| rdData | output | NUM_OUT | Read data |
| relayPin | output | NUM_OUT | Active-low output pins |

## Verification
A host write and an expiring guard with a pending request can land on the same clock edge. The bench provokes this on purpose. It first leaves an early compressor request pending. It then writes the compressor's current value on exactly the edge where the interval ends. The result is judged at the pins and at the pending readback on that edge and on the next one: the pin must not move and the flag must drop. A separate pump case checks the opposite outcome, where no write arrives and the held value reaches the pin on the last cycle of its interval and not one cycle earlier.

// File: rtl/relay_out_pkg.sv
package relay_out_pkg;
  localparam int N_GUARD   = 2;
  localparam int OUT_ADDR  = 0;
  localparam int STAT_ADDR = 1;

  typedef struct packed {
    logic               latchWr;
    logic [N_GUARD-1:0] gApply;
    logic [N_GUARD-1:0] gVal;
    logic [N_GUARD-1:0] gSetPend;
    logic [N_GUARD-1:0] gClrPend;
  } relay_strb_t;
endpackage

// File: rtl/relay_out_ctrl.sv
module relay_out_ctrl
  import relay_out_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CYC_PER_SEC = 100_000_000,
  parameter int CMP_SEC     = 20,
  parameter int PMP_SEC     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [N_GUARD-1:0] guardWr,
  input  logic [N_GUARD-1:0] guardCur,
  input  logic [N_GUARD-1:0] pendFlag,
  input  logic [N_GUARD-1:0] pendVal,
  output relay_strb_t        strb
);
  localparam int MAX_SEC = (CMP_SEC > PMP_SEC) ? CMP_SEC : PMP_SEC;
  localparam int SEC_W   = $clog2(MAX_SEC + 1);
  localparam int CYC_W   = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;

  logic wrHit;
  logic [N_GUARD-1:0] applyV, valV, setV, clrV;

  assign wrHit = wrEn && (wrAddr == ADDR_W'(OUT_ADDR));

  for (genvar g = 0; g < N_GUARD; g++) begin : gGuard
    localparam int SEC  = (g == 0) ? CMP_SEC : PMP_SEC;
    localparam int SPAN = SEC * CYC_PER_SEC;

    logic [SEC_W-1:0] secLeft;
    logic [CYC_W-1:0] cycCnt;
    logic ready;
    logic apply, val, setP, clrP;

    // ready also covers the last cycle of the interval, so that the gap is exact
    assign ready = (secLeft == '0) ||
                   ((secLeft == SEC_W'(1)) && (cycCnt == CYC_W'(CYC_PER_SEC - 1)));

    always_comb begin
      apply = 1'b0;
      val   = guardCur[g];
      setP  = 1'b0;
      clrP  = 1'b0;
      if (wrHit) begin
        if (guardWr[g] != guardCur[g]) begin
          val = guardWr[g];
          if (ready) begin
            apply = 1'b1;
            clrP  = 1'b1;
          end else begin
            setP = 1'b1;
          end
        end else begin
          clrP = 1'b1;
        end
      end else if (pendFlag[g] && ready) begin
        apply = 1'b1;
        val   = pendVal[g];
        clrP  = 1'b1;
      end
    end

    assign applyV[g] = apply;
    assign valV[g]   = val;
    assign setV[g]   = setP;
    assign clrV[g]   = clrP;

    always_ff @(posedge clk) begin
      if (rst) begin
        secLeft <= '0;
        cycCnt  <= '0;
      end else if (apply) begin
        secLeft <= SEC_W'(SEC);
        cycCnt  <= '0;
      end else if (secLeft != '0) begin
        if (cycCnt == CYC_W'(CYC_PER_SEC - 1)) begin
          cycCnt  <= '0;
          secLeft <= secLeft - SEC_W'(1);
        end else begin
          cycCnt <= cycCnt + CYC_W'(1);
        end
      end
    end

    // gap watch: counts edges since the pin last moved
    logic        prevBit;
    logic [31:0] gapCnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        prevBit <= 1'b1;
        gapCnt  <= 32'(SPAN);
      end else begin
        prevBit <= guardCur[g];
        if (guardCur[g] != prevBit) gapCnt <= 32'd1;
        else if (gapCnt < 32'(SPAN)) gapCnt <= gapCnt + 32'd1;
      end
    end

    // R4 R5
    min_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (guardCur[g] != prevBit) |-> (gapCnt >= 32'(SPAN)));

    // R6
    pend_apply_chk: assert property (@(posedge clk) disable iff (rst)
      (pendFlag[g] && ready && !wrHit) |=> (guardCur[g] != $past(guardCur[g])));
  end

  always_comb begin
    strb.latchWr  = wrHit;
    strb.gApply   = applyV;
    strb.gVal     = valV;
    strb.gSetPend = setV;
    strb.gClrPend = clrV;
  end
endmodule

// File: rtl/relay_out_dp.sv
module relay_out_dp
  import relay_out_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 2,
  parameter int CMP_BIT = 0,
  parameter int PMP_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  relay_strb_t        strb,
  input  logic [NUM_OUT-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_OUT-1:0] pins,
  output logic [N_GUARD-1:0] pendFlag,
  output logic [N_GUARD-1:0] pendVal,
  output logic [NUM_OUT-1:0] rdData
);
  localparam logic [NUM_OUT-1:0] GUARD_MASK =
    (NUM_OUT'(1) << CMP_BIT) | (NUM_OUT'(1) << PMP_BIT);

  logic [NUM_OUT-1:0] nextPins;

  always_comb begin
    nextPins = pins;
    if (strb.latchWr) nextPins = (pins & GUARD_MASK) | (wrData & ~GUARD_MASK);
    if (strb.gApply[0]) nextPins[CMP_BIT] = strb.gVal[0];
    if (strb.gApply[1]) nextPins[PMP_BIT] = strb.gVal[1];
  end

  always_ff @(posedge clk) begin
    if (rst) pins <= '1;
    else     pins <= nextPins;
  end

  for (genvar g = 0; g < N_GUARD; g++) begin : gPend
    always_ff @(posedge clk) begin
      if (rst) begin
        pendFlag[g] <= 1'b0;
        pendVal[g]  <= 1'b1;
      end else if (strb.gSetPend[g]) begin
        pendFlag[g] <= 1'b1;
        pendVal[g]  <= strb.gVal[g];
      end else if (strb.gClrPend[g]) begin
        pendFlag[g] <= 1'b0;
      end
    end

    // R6
    pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pendFlag[g]) |-> $past(strb.latchWr));
  end

  always_comb begin
    if (rdAddr == ADDR_W'(OUT_ADDR))       rdData = pins;
    else if (rdAddr == ADDR_W'(STAT_ADDR)) rdData = NUM_OUT'(pendFlag);
    else                                   rdData = '0;
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.latchWr && (strb.gApply == '0)) |=> $stable(pins));
endmodule

// File: rtl/relay_out.sv
module relay_out
  import relay_out_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int ADDR_W      = 2,
  parameter int CYC_PER_SEC = 100_000_000,
  parameter int CMP_SEC     = 20,
  parameter int PMP_SEC     = 10,
  parameter int CMP_BIT     = 0,
  parameter int PMP_BIT     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_OUT-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_OUT-1:0] rdData,
  output logic [NUM_OUT-1:0] relayPin
);
  relay_strb_t        strb;
  logic [N_GUARD-1:0] pendFlag, pendVal, guardWr, guardCur;
  logic [NUM_OUT-1:0] pins;

  assign guardWr  = {wrData[PMP_BIT], wrData[CMP_BIT]};
  assign guardCur = {pins[PMP_BIT], pins[CMP_BIT]};
  assign relayPin = pins;

  relay_out_ctrl #(
    .ADDR_W(ADDR_W), .CYC_PER_SEC(CYC_PER_SEC),
    .CMP_SEC(CMP_SEC), .PMP_SEC(PMP_SEC)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .guardWr(guardWr), .guardCur(guardCur),
    .pendFlag(pendFlag), .pendVal(pendVal), .strb(strb)
  );

  relay_out_dp #(
    .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W),
    .CMP_BIT(CMP_BIT), .PMP_BIT(PMP_BIT)
  ) uDp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .rdAddr(rdAddr),
    .pins(pins), .pendFlag(pendFlag), .pendVal(pendVal), .rdData(rdData)
  );
endmodule

// File: tb/sim_relay_out.sv
module sim_relay_out;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData, relayPin;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit summed = 0;

  typedef struct {
    int       at;
    logic [7:0] pins;
    logic [1:0] pend;
    string    tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  relay_out #(.NUM_OUT(8), .ADDR_W(2), .CYC_PER_SEC(10),
              .CMP_SEC(20), .PMP_SEC(10), .CMP_BIT(0), .PMP_BIT(1)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .relayPin(relayPin)
  );

  task automatic expectAt(input int at, input logic [7:0] p,
                          input logic [1:0] pd, input string tag);
    item_t it;
    it.at = at; it.pins = p; it.pend = pd; it.tag = tag;
    sbq.push_back(it);
  endtask

  // drive a write sampled by edge number t
  task automatic wrAt(input int t, input logic [1:0] a, input logic [7:0] d);
    while (cyc < t - 1) @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // monitor: pops scoreboard items when their edge has been reached
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        item_t it;
        it = sbq.pop_front();
        if (it.at != cyc) begin
          checks++; errors++;
          $display("FAIL %s item for edge %0d missed, now %0d", it.tag, it.at, cyc);
        end else begin
          rdAddr = 2'd0; #1;
          checks++;
          if (relayPin !== it.pins || rdData !== it.pins) begin
            errors++;
            $display("FAIL %s R10 edge %0d pins %h read %h expected %h",
                     it.tag, cyc, relayPin, rdData, it.pins);
          end
          rdAddr = 2'd1; #1;
          checks++;
          if (rdData !== {6'd0, it.pend}) begin
            errors++;
            $display("FAIL %s edge %0d pending %h expected %h",
                     it.tag, cyc, rdData, {6'd0, it.pend});
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expectAt(10, 8'hFF, 2'b00, "R1 reset");
    // both guards start expired
    expectAt(20, 8'hF0, 2'b00, "R1 first guarded write");
    wrAt(20, 2'd0, 8'hF0);
    expectAt(30, 8'h0C, 2'b11, "R2 R6 early requests held");
    wrAt(30, 2'd0, 8'h0F);
    expectAt(40, 8'h0C, 2'b01, "R7 pump cancel");
    wrAt(40, 2'd0, 8'h0D);
    expectAt(120, 8'h0C, 2'b01, "R7 no change at pump expiry");
    expectAt(130, 8'h0E, 2'b01, "R8 pump timer not restarted");
    wrAt(130, 2'd0, 8'h0F);
    expectAt(219, 8'h0E, 2'b01, "R4 compressor still held");
    expectAt(220, 8'h0F, 2'b00, "R6 compressor applied at expiry");
    expectAt(230, 8'h0F, 2'b01, "R6 compressor early request");
    wrAt(230, 2'd0, 8'h0E);
    // write on the same edge as compressor expiry with pending
    expectAt(420, 8'h0F, 2'b00, "R9 write wins at expiry");
    expectAt(421, 8'h0F, 2'b00, "R9 pin stays after cancel");
    wrAt(420, 2'd0, 8'h0F);
    expectAt(425, 8'h0E, 2'b00, "R4 change once interval passed");
    wrAt(425, 2'd0, 8'h0E);
    expectAt(430, 8'h0E, 2'b00, "R3 other address ignored");
    wrAt(430, 2'd2, 8'h00);
    expectAt(440, 8'h0C, 2'b00, "R5 pump immediate");
    wrAt(440, 2'd0, 8'h0C);
    expectAt(450, 8'h0C, 2'b10, "R5 pump early request");
    wrAt(450, 2'd0, 8'h0E);
    expectAt(539, 8'h0C, 2'b10, "R5 pump held one cycle before");
    expectAt(540, 8'h0E, 2'b00, "R5 pump applied at expiry");
    expectAt(560, 8'hA6, 2'b00, "R2 unguarded bits");
    wrAt(560, 2'd0, 8'hA6);
    expectAt(570, 8'hA6, 2'b00, "R2 hold");
    while (sbq.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    if (!summed) begin
      summed = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    #2000000;
    if (!done && !summed) begin
      summed = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at edge %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule